// File: doc/BRIEF.md
# Pattern-and-Checksum RAM Self-Test Engine

This block exercises an on-chip RAM through the RAM's own address, write-data, write-enable and read-data pins. After a start pulse it writes the complementary patterns 0x5555...5 and 0xAAAA...A into the array and reads every written word back. Each read value goes into a wrap-around checksum. No word is compared on its own. The block makes one pass/fail decision at the end, when it compares the checksum with an expected constant for the selected plan.

Two plans are available, and the `mode` input chooses one when a start is accepted:

- **Data-array plan.** Each word is written and then read back at once, with the pattern alternating from one address to the next.
- **Tag-toggling plan.** There are three full sweeps. Each sweep fills the whole array and then reads it all back. Both the data pattern and an address scramble mask change from sweep to sweep, so the address lines toggle as well.

The expected constants are parameters. Their defaults equal the sum that a fault-free RAM returns.

Top module: `ram_pattern_bist`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, `pass` and `ram_we` are 0 after that edge.
- R2: `start` is accepted only when no test is in progress. A start that arrives during a test is ignored, and so is any change of `mode` during a test. The plan is latched from `mode` at the accepted start (0 = data-array plan, 1 = tag-toggling plan).
- R3: In the data-array plan, word index a runs from 0 to DEPTH-1 in ascending order. Word a is written with 0x55555555 when a is even and with 0xAAAAAAAA when a is odd. In the cycle after each write, that same address is read. There are exactly DEPTH writes.
- R4: The tag-toggling plan makes three sweeps, p = 0, 1, 2. Sweep p first writes every index i = 0..DEPTH-1 to address i XOR M(p). It then reads all of them back in the same order. M(p) is the low ADDR_W bits of 0x55...5 when p is even and of 0xAA...A when p is odd. The write data is 0x55555555 when p is even and 0xAAAAAAAA when p is odd. There are exactly 3*DEPTH writes.
- R5: Each read value is registered once after the RAM latency and then added into a DATA_W-bit wrap-around sum. The sum restarts at zero on every accepted start.
- R6: At the end of a test, `pass` is 1 exactly when the final sum equals EXP_DATA (data plan) or EXP_TAG (tag plan). A corrupted read that changes the sum gives `pass` = 0.
- R7: `done` is a one-cycle pulse. With RAM_LAT = 1 it is high in the cycle that comes 2*DEPTH+4 cycles (data plan) or 6*DEPTH+4 cycles (tag plan) after the cycle in which `start` was sampled.
- R8: `pass` is 0 from the cycle after an accepted start. It then holds its value from the `done` cycle until the next accepted start.
- R9: `ram_we` is 0 whenever no test is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a test, honoured when idle |
| mode | input | 1 | Plan select: 0 data-array, 1 tag-toggling |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | DATA_W | RAM read data, valid RAM_LAT cycles after the address |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | Result of the last completed test |

## Verification
The properties assume that `ram_rdata` follows the address by exactly RAM_LAT cycles. They also assume that `start` and `mode` may change at any cycle, including in the middle of a test. The stimulus keeps a RAM model with a fixed one-cycle latency. It then deliberately raises `start` with the other `mode` value in the middle of a run, to confirm that this has no effect. Faults are injected only through the model's read path: a stuck bit on one word, in one case where the patterns hide it and in one where they expose it. In every case the pass verdict is predicted from the sum of the values the model actually returned.

// File: rtl/bist_pkg.sv
// Shared types for the pattern-and-checksum RAM self-test engine.
// Assumes nothing beyond a single clock domain.
package bist_pkg;
    typedef enum logic {
        MODE_DATA = 1'b0,
        MODE_TAG  = 1'b1
    } bist_mode_e;

    typedef enum logic {
        PH_WRITE = 1'b0,
        PH_READ  = 1'b1
    } bist_phase_e;

    localparam int TAG_SWEEPS = 3;
endpackage

// File: rtl/bist_sequencer.sv
// Address and pattern sequencer. It steps through the write/read schedule of
// the selected plan, one RAM access per cycle, and stops after the last read.
// Assumes start_ok is raised only while idle (the top module guarantees this).
module bist_sequencer
    import bist_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  bist_mode_e        mode_i,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              we,
    output logic              rd_issue
);
    localparam logic [DATA_W-1:0] PAT_LO   = {(DATA_W/2){2'b01}};
    localparam logic [DATA_W-1:0] PAT_HI   = {(DATA_W/2){2'b10}};
    localparam logic [ADDR_W-1:0] MASK_LO  = PAT_LO[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] MASK_HI  = PAT_HI[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] IDX_LAST = {ADDR_W{1'b1}};
    localparam logic [1:0]        SWP_LAST = 2'(TAG_SWEEPS - 1);

    logic              busy_q;
    bist_mode_e        mode_q;
    bist_phase_e       phase_q, phase_d;
    logic [1:0]        swp_q, swp_d;
    logic [ADDR_W-1:0] idx_q, idx_d;
    logic              last_step;
    logic              use_hi;

    // Next position in the schedule for the latched plan.
    always_comb begin
        idx_d   = idx_q;
        phase_d = phase_q;
        swp_d   = swp_q;
        if (mode_q == MODE_DATA) begin
            if (phase_q == PH_WRITE) begin
                phase_d = PH_READ;
            end else begin
                phase_d = PH_WRITE;
                idx_d   = idx_q + 1'b1;
            end
        end else begin
            idx_d = idx_q + 1'b1;
            if (idx_q == IDX_LAST) begin
                if (phase_q == PH_WRITE) begin
                    phase_d = PH_READ;
                end else begin
                    phase_d = PH_WRITE;
                    swp_d   = swp_q + 1'b1;
                end
            end
        end
    end

    // Final read of the plan: the run ends after this access.
    always_comb begin
        last_step = busy_q && (phase_q == PH_READ) && (idx_q == IDX_LAST)
                    && ((mode_q == MODE_DATA) || (swp_q == SWP_LAST));
    end

    // Schedule state: load on accepted start, advance while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            mode_q  <= MODE_DATA;
            phase_q <= PH_WRITE;
            swp_q   <= '0;
            idx_q   <= '0;
        end else if (start_ok) begin
            busy_q  <= 1'b1;
            mode_q  <= mode_i;
            phase_q <= PH_WRITE;
            swp_q   <= '0;
            idx_q   <= '0;
        end else if (busy_q) begin
            if (last_step) begin
                busy_q <= 1'b0;
            end else begin
                idx_q   <= idx_d;
                phase_q <= phase_d;
                swp_q   <= swp_d;
            end
        end
    end

    // Pattern choice: per word in the data plan, per sweep in the tag plan.
    always_comb begin
        use_hi = (mode_q == MODE_DATA) ? idx_q[0] : swp_q[0];
    end

    // RAM-side outputs; addresses are scrambled only in the tag plan.
    always_comb begin
        if (mode_q == MODE_TAG) begin
            addr = idx_q ^ (swp_q[0] ? MASK_HI : MASK_LO);
        end else begin
            addr = idx_q;
        end
        wdata    = use_hi ? PAT_HI : PAT_LO;
        we       = busy_q && (phase_q == PH_WRITE);
        rd_issue = busy_q && (phase_q == PH_READ);
        busy     = busy_q;
    end
endmodule

// File: rtl/bist_read_pipe.sv
// Read-return tracker. It delays the read-issue flag by the RAM latency and
// registers the returned word once before it is summed.
// Assumes ram_rdata is valid exactly RAM_LAT cycles after the read address.
module bist_read_pipe #(
    parameter int DATA_W  = 32,
    parameter int RAM_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_valid,
    output logic              in_flight
);
    logic [RAM_LAT-1:0] lat_v;

    generate
        if (RAM_LAT == 1) begin : g_lat_one
            // Single-stage latency tracker.
            always_ff @(posedge clk) begin
                if (!rst_n) lat_v <= '0;
                else        lat_v <= issue;
            end
        end else begin : g_lat_multi
            // Shift register matching a multi-cycle RAM latency.
            always_ff @(posedge clk) begin
                if (!rst_n) lat_v <= '0;
                else        lat_v <= {lat_v[RAM_LAT-2:0], issue};
            end
        end
    endgenerate

    // Capture the returned word in the cycle it is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            cap_valid <= lat_v[RAM_LAT-1];
            if (lat_v[RAM_LAT-1]) cap_data <= ram_rdata;
        end
    end

    // Any read still travelling towards the sum.
    always_comb begin
        in_flight = (|lat_v) || cap_valid;
    end
endmodule

// File: rtl/bist_checksum.sv
// Wrap-around accumulator for read-back words.
// Assumes clear and add_en are never high together (clear comes only while idle).
module bist_checksum #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic [DATA_W-1:0] add_val,
    output logic [DATA_W-1:0] sum
);
    // Running sum, modulo 2**DATA_W.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum <= '0;
        else if (clear)  sum <= '0;
        else if (add_en) sum <= sum + add_val;
    end
endmodule

// File: rtl/ram_pattern_bist.sv
// Top of the RAM self-test engine. It accepts a start while idle, runs the
// chosen plan against the RAM pins, waits for the last read to reach the sum,
// then pulses done and reports pass for the single end-of-test comparison.
// Assumes the RAM has a fixed read latency of RAM_LAT cycles.
module ram_pattern_bist
    import bist_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int RAM_LAT = 1,
    parameter logic [DATA_W-1:0] EXP_DATA =
        DATA_W'(2 ** (ADDR_W - 1)) * {DATA_W{1'b1}},
    parameter logic [DATA_W-1:0] EXP_TAG =
        DATA_W'(2 ** ADDR_W) * ({(DATA_W/2){2'b01}} + {(DATA_W/2){2'b01}}
                                + {(DATA_W/2){2'b10}})
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              done,
    output logic              pass
);
    logic              run_q;
    bist_mode_e        mode_q;
    logic              done_q, pass_q;
    logic              start_ok, finish;
    logic              seq_busy, rd_issue;
    logic              cap_valid, in_flight;
    logic [DATA_W-1:0] cap_data, sum;
    logic [DATA_W-1:0] expected;

    // Start is honoured only when no test is running; finish once drained.
    always_comb begin
        start_ok = start && !run_q;
        finish   = run_q && !seq_busy && !in_flight;
        expected = (mode_q == MODE_TAG) ? EXP_TAG : EXP_DATA;
    end

    bist_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_ok),
        .mode_i   (bist_mode_e'(mode)),
        .busy     (seq_busy),
        .addr     (ram_addr),
        .wdata    (ram_wdata),
        .we       (ram_we),
        .rd_issue (rd_issue)
    );

    bist_read_pipe #(
        .DATA_W  (DATA_W),
        .RAM_LAT (RAM_LAT)
    ) u_rdp (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (rd_issue),
        .ram_rdata (ram_rdata),
        .cap_data  (cap_data),
        .cap_valid (cap_valid),
        .in_flight (in_flight)
    );

    bist_checksum #(
        .DATA_W (DATA_W)
    ) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_ok),
        .add_en  (cap_valid),
        .add_val (cap_data),
        .sum     (sum)
    );

    // Run flag, latched plan, done pulse and held verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= MODE_DATA;
            done_q <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (start_ok) begin
                run_q  <= 1'b1;
                mode_q <= bist_mode_e'(mode);
                pass_q <= 1'b0;
            end else if (finish) begin
                run_q  <= 1'b0;
                pass_q <= (sum == expected);
            end
        end
    end

    assign done = done_q;
    assign pass = pass_q;
endmodule

// File: rtl/ram_pattern_bist_chk.sv
// Property checker for ram_pattern_bist, attached by bind below.
// Assumes reset is asserted from time zero.
module ram_pattern_bist_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              pass,
    input logic              ram_we,
    input logic [DATA_W-1:0] ram_wdata,
    input logic              run_q,
    input logic              start_ok
);
    localparam logic [DATA_W-1:0] PAT_LO = {(DATA_W/2){2'b01}};
    localparam logic [DATA_W-1:0] PAT_HI = {(DATA_W/2){2'b10}};

    p_we_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> run_q);

    p_wdata_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_wdata == PAT_LO || ram_wdata == PAT_HI));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(run_q) && !run_q));

    p_pass_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass) |-> done);

    p_pass_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pass) |-> $past(start_ok));
endmodule

bind ram_pattern_bist ram_pattern_bist_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .pass      (pass),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .run_q     (run_q),
    .start_ok  (start_ok)
);

// File: tb/sim_ram_pattern_bist.sv
// Bench: full runs of both plans on a 256-word model RAM, with injected read faults.
module sim_ram_pattern_bist;
    localparam int AW = 8;
    localparam int D  = 2 ** AW;
    localparam logic [31:0] A5 = 32'h5555_5555;
    localparam logic [31:0] AA = 32'hAAAA_AAAA;
    localparam logic [31:0] EXP_D = 32'(D / 2) * 32'hFFFF_FFFF;
    localparam logic [31:0] EXP_T = 32'(D) * (A5 + A5 + AA);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [AW-1:0] ram_addr;
    logic [31:0]   ram_wdata;
    logic          ram_we;
    logic [31:0]   ram_rdata;
    logic          done, pass;

    logic [31:0] mem [0:D-1];
    int          fkind = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    ram_pattern_bist #(
        .ADDR_W (AW), .DATA_W (32), .RAM_LAT (1),
        .EXP_DATA (EXP_D), .EXP_TAG (EXP_T)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .mode (mode),
        .ram_addr (ram_addr), .ram_wdata (ram_wdata), .ram_we (ram_we),
        .ram_rdata (ram_rdata), .done (done), .pass (pass)
    );

    function automatic logic [31:0] rd_val(input logic [AW-1:0] a);
        logic [31:0] v;
        v = mem[a];
        if (fkind == 1 && a == 3) v[0] = 1'b1;
        if (fkind == 2 && a == 0) v[31] = 1'b0;
        return v;
    endfunction

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        ram_rdata <= rd_val(ram_addr);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected address and data of access k of the given plan and phase.
    function automatic logic [AW-1:0] exp_addr(input logic m, input int k);
        int p;
        if (!m) return AW'(k);
        p = k / D;
        return AW'(k % D) ^ ((p % 2 == 1) ? 8'hAA : 8'h55);
    endfunction

    function automatic logic [31:0] exp_data(input logic m, input int k);
        if (!m) return (k % 2 == 1) ? AA : A5;
        return ((k / D) % 2 == 1) ? AA : A5;
    endfunction

    task automatic run_test(input logic m, input int fk, input bit stray, input string tag);
        int          window, wrs, rds, bad, lat, dcnt;
        logic [31:0] rsum;
        logic        held;
        bit          moved, seen, exp_pass;
        window = m ? 6 * D : 2 * D;
        wrs = 0; rds = 0; bad = 0; lat = 0; dcnt = 0; rsum = '0;
        held = 1'b0; moved = 0; seen = 0;
        @(negedge clk);
        mode = m; start = 1'b1; fkind = fk;
        @(negedge clk);
        start = 1'b0;
        for (int n = 1; n <= window + 40; n++) begin
            if (n == 1) check(pass == 1'b0, "R8", {tag, " pass cleared after start"}, 32'(pass), 0);
            if (n <= window) begin
                if (ram_we) begin
                    if (ram_addr != exp_addr(m, wrs) || ram_wdata != exp_data(m, wrs)) bad++;
                    wrs++;
                end else begin
                    if (ram_addr != exp_addr(m, rds)) bad++;
                    rsum += rd_val(ram_addr);
                    rds++;
                end
            end else if (ram_we) begin
                bad++;
            end
            if (done) begin
                dcnt++;
                if (!seen) begin seen = 1; lat = n; held = pass; end
            end else if (seen && pass !== held) begin
                moved = 1;
            end
            if (stray && n == 100) begin start = 1'b1; mode = ~m; end
            if (stray && n == 101) begin start = 1'b0; mode = m; end
            @(negedge clk);
        end
        exp_pass = (rsum == (m ? EXP_T : EXP_D));
        check(dcnt == 1, "R7", {tag, " done pulse count"}, 32'(dcnt), 1);
        check(lat == window + 4, "R7", {tag, " done latency"}, 32'(lat), 32'(window + 4));
        check(wrs == (m ? 3 * D : D), m ? "R4" : "R3", {tag, " write count"},
              32'(wrs), 32'(m ? 3 * D : D));
        check(bad == 0, m ? "R4" : "R3", {tag, " address/data sequence errors"}, 32'(bad), 0);
        check(held == exp_pass, "R6", {tag, " verdict vs bench sum (R5)"}, 32'(held), 32'(exp_pass));
        check(!moved, "R8", {tag, " pass held after done"}, 32'(moved), 0);
        if (stray) check(wrs == D && held == 1'b1, "R2", {tag, " stray start ignored"}, 32'(wrs), D);
    endtask

    task automatic check_mem(input logic m, input string req);
        int errs;
        errs = 0;
        for (int a = 0; a < D; a++) begin
            if (mem[a] != (m ? A5 : ((a % 2 == 1) ? AA : A5))) errs++;
        end
        check(errs == 0, req, "final array contents", 32'(errs), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL R7 watchdog expired: actual timeout expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int a = 0; a < D; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && pass == 1'b0 && ram_we == 1'b0, "R1", "reset outputs",
              {29'd0, done, pass, ram_we}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(ram_we == 1'b0 && done == 1'b0, "R9", "idle write enable", 32'(ram_we), 0);
        end
        run_test(1'b0, 0, 0, "data good");
        check_mem(1'b0, "R3");
        run_test(1'b1, 0, 0, "tag good");
        check_mem(1'b1, "R4");
        run_test(1'b0, 1, 0, "data stuck1");
        check(pass == 1'b0, "R6", "data stuck1 must fail", 32'(pass), 0);
        run_test(1'b1, 1, 0, "tag stuck1");
        check(pass == 1'b0, "R6", "tag stuck1 must fail", 32'(pass), 0);
        run_test(1'b0, 2, 0, "data hidden fault");
        check(pass == 1'b1, "R6", "data hidden fault passes", 32'(pass), 1);
        run_test(1'b1, 2, 0, "tag exposed fault");
        check(pass == 1'b0, "R6", "tag exposed fault fails", 32'(pass), 0);
        run_test(1'b0, 0, 1, "data stray start");
        run_test(1'b1, 0, 0, "tag after fail");
        check(pass == 1'b1, "R5", "sum restarts at zero", 32'(pass), 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(ram_we == 1'b0, "R9", "no writes after run", 32'(ram_we), 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule